// File: doc/BRIEF.md
# Range-Decoded Stream Crossbar with Held Grants

This block connects several valid/ready stream inputs to several stream outputs. Each beat carries a destination field, and every output owns an inclusive address window, given as a low and a high bound. An input's beat goes to the lowest-numbered output whose window holds the destination, as long as a link mask permits that input/output pair. A beat whose destination finds no permitted window is absorbed at once: the input sees ready and the beat is discarded, and a per-input error line goes high in that same cycle.

Each output has its own arbiter. Once an input wins an output, it keeps that output until a release event occurs. A release event is one of three: a beat with the last flag, a set number of beats, or a run of cycles in which the owner presents nothing. Each of the three can be switched on or off by a parameter. Arbitration is either rotating, where the search starts after the previous winner, or fixed, where the lowest index wins.

Back-pressure works as follows. A granted input's ready equals the ready of the output it is routed to. An output's valid, data, last flag and destination stay unchanged for as long as its ready is low. Inputs must keep a presented beat stable until it is accepted.

Top module: `strm_xbar`

## Requirements
- R1: A beat whose destination lies in output o's inclusive window [DEST_LO slice o, DEST_HI slice o], with link bit LINK[i*N_OUT+o] set, appears on output o with its data, last flag and destination unchanged. When windows overlap, the lowest permitted output index wins. A granted beat moves in the same cycle it is presented.
- R2: A beat whose destination matches no permitted window is accepted with s_ready high in the cycle it is presented. It raises dec_err for that input in that cycle and appears on no output.
- R3: While an input owns an output, no other input is served by that output, even when the owner is idle and others are requesting.
- R4: With REL_LAST set, a beat with the last flag that moves ends the grant, and the output can be re-arbitrated in the next cycle.
- R5: With MAX_XFER non-zero, the grant ends when the MAX_XFER-th beat of that grant moves.
- R6: With IDLE_TO non-zero, the grant ends after IDLE_TO consecutive cycles in which the owner does not present a beat routed to that output. The next requester is served in the following cycle.
- R7: With USE_RR set, the search for a new owner starts at the input after the previous owner and wraps around.
- R8: With USE_RR clear, the lowest-indexed requesting input always wins a free output.
- R9: While an output's valid is high and its ready is low, the output's valid, data, last flag and destination hold, and the owning input's s_ready stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | N_IN | Per-input beat valid |
| s_ready | output | N_IN | Per-input beat accepted |
| s_data | input | N_IN*DW | Per-input data, input i at slice i |
| s_last | input | N_IN | Per-input end-of-packet flag |
| s_dest | input | N_IN*DESTW | Per-input destination field |
| m_valid | output | N_OUT | Per-output beat valid |
| m_ready | input | N_OUT | Per-output downstream ready |
| m_data | output | N_OUT*DW | Per-output data |
| m_last | output | N_OUT | Per-output end-of-packet flag |
| m_dest | output | N_OUT*DESTW | Per-output destination field |
| dec_err | output | N_IN | High in a cycle where that input's beat is dropped for having no route |

## Verification
The hardest case to reach is an idle-timeout release: an owner must win an output, hand over a beat without the last flag, and then go silent while a rival waits. The rival has to stay blocked for exactly the timeout window and then be served in the next cycle. Directed sequences build this case and the transfer-count release on purpose, with the rotating pointer steered into a known position beforehand. After that, a long run of random destinations, last flags and downstream stalls checks every moved beat against a bench routing function.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  function automatic int unsigned idx_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic int unsigned cnt_w(int unsigned lim);
    return (lim > 1) ? $clog2(lim + 1) : 1;
  endfunction
endpackage

// File: rtl/xbar_dec.sv
module xbar_dec #(
  parameter int N_OUT = 2,
  parameter int DESTW = 4,
  parameter logic [N_OUT-1:0]       LINK = '1,
  parameter logic [N_OUT*DESTW-1:0] LO   = '0,
  parameter logic [N_OUT*DESTW-1:0] HI   = '1
) (
  input  logic             valid,
  input  logic [DESTW-1:0] dest,
  output logic [N_OUT-1:0] route,
  output logic             miss
);
  logic found;

  always_comb begin
    route = '0;
    found = 1'b0;
    for (int o = 0; o < N_OUT; o++) begin
      if (!found && LINK[o] && dest >= LO[o*DESTW +: DESTW] && dest <= HI[o*DESTW +: DESTW]) begin
        route[o] = 1'b1;
        found    = 1'b1;
      end
    end
    miss = valid && !found;
  end
endmodule

// File: rtl/xbar_arb.sv
module xbar_arb #(
  parameter int N_IN     = 3,
  parameter int USE_RR   = 1,
  parameter int REL_LAST = 1,
  parameter int MAX_XFER = 4,
  parameter int IDLE_TO  = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [N_IN-1:0]                  req,
  input  logic [N_IN-1:0]                  last_in,
  input  logic                             out_ready,
  output logic                             act,
  output logic [xbar_pkg::idx_w(N_IN)-1:0] sel
);
  localparam int IW = xbar_pkg::idx_w(N_IN);
  localparam int CW = xbar_pkg::cnt_w(MAX_XFER);
  localparam int TW = xbar_pkg::cnt_w(IDLE_TO);

  logic          locked;
  logic [IW-1:0] owner, prev, pick;
  logic [CW-1:0] xcnt, cnt_now;
  logic [TW-1:0] icnt;
  logic          any, found, fire, rel, idle_hit;
  int            c;

  always_comb begin
    any   = |req;
    pick  = '0;
    found = 1'b0;
    c     = 0;
    for (int k = 0; k < N_IN; k++) begin
      if (USE_RR != 0) c = (int'(prev) + 1 + k) % N_IN;
      else             c = k;
      if (!found && req[c]) begin
        pick  = IW'(c);
        found = 1'b1;
      end
    end
  end

  assign sel      = locked ? owner : pick;
  assign act      = locked ? req[owner] : any;
  assign fire     = act && out_ready;
  assign cnt_now  = locked ? xcnt : '0;
  assign rel      = ((REL_LAST != 0) && last_in[sel]) ||
                    ((MAX_XFER != 0) && (32'(cnt_now) + 1 >= MAX_XFER));
  assign idle_hit = (IDLE_TO != 0) && (32'(icnt) + 1 >= IDLE_TO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked <= 1'b0;
      owner  <= '0;
      prev   <= IW'(N_IN - 1);
      xcnt   <= '0;
      icnt   <= '0;
    end else if (!locked) begin
      if (any) begin
        owner  <= pick;
        prev   <= pick;
        locked <= !(fire && rel);
        xcnt   <= CW'(fire);
        icnt   <= '0;
      end
    end else if (fire) begin
      icnt <= '0;
      if (rel) begin
        locked <= 1'b0;
        xcnt   <= '0;
      end else begin
        xcnt <= xcnt + 1'b1;
      end
    end else if (!req[owner]) begin
      if (idle_hit) begin
        locked <= 1'b0;
        icnt   <= '0;
        xcnt   <= '0;
      end else begin
        icnt <= icnt + 1'b1;
      end
    end else begin
      icnt <= '0;
    end
  end

  // R9: a stalled offer keeps its source
  p_stall_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    act && !out_ready |=> act && sel == $past(sel));

  // R3: an owner that is still presenting keeps the output
  p_hold_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
    locked && !fire && req[owner] |=> locked && owner == $past(owner));

  generate
    if (MAX_XFER > 0) begin : g_cnt_chk
      p_xfer_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> 32'(xcnt) < MAX_XFER);
    end
    if (IDLE_TO > 0) begin : g_idle_chk
      p_idle_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        32'(icnt) < IDLE_TO);
    end
  endgenerate
endmodule

// File: rtl/strm_xbar.sv
module strm_xbar #(
  parameter int N_IN     = 3,
  parameter int N_OUT    = 2,
  parameter int DW       = 16,
  parameter int DESTW    = 4,
  parameter int USE_RR   = 1,
  parameter int REL_LAST = 1,
  parameter int MAX_XFER = 4,
  parameter int IDLE_TO  = 3,
  parameter logic [N_IN*N_OUT-1:0]  LINK    = '1,
  parameter logic [N_OUT*DESTW-1:0] DEST_LO = '0,
  parameter logic [N_OUT*DESTW-1:0] DEST_HI = '1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_IN-1:0]        s_valid,
  output logic [N_IN-1:0]        s_ready,
  input  logic [N_IN*DW-1:0]     s_data,
  input  logic [N_IN-1:0]        s_last,
  input  logic [N_IN*DESTW-1:0]  s_dest,
  output logic [N_OUT-1:0]       m_valid,
  input  logic [N_OUT-1:0]       m_ready,
  output logic [N_OUT*DW-1:0]    m_data,
  output logic [N_OUT-1:0]       m_last,
  output logic [N_OUT*DESTW-1:0] m_dest,
  output logic [N_IN-1:0]        dec_err
);
  localparam int IW = xbar_pkg::idx_w(N_IN);

  logic [N_OUT-1:0] route [N_IN];
  logic [N_IN-1:0]  miss;
  logic [N_IN-1:0]  want  [N_OUT];
  logic [IW-1:0]    sel   [N_OUT];
  logic [N_OUT-1:0] gmat  [N_IN];

  generate
    for (genvar i = 0; i < N_IN; i++) begin : g_in
      xbar_dec #(
        .N_OUT(N_OUT), .DESTW(DESTW),
        .LINK(LINK[i*N_OUT +: N_OUT]), .LO(DEST_LO), .HI(DEST_HI)
      ) u_dec (
        .valid(s_valid[i]),
        .dest (s_dest[i*DESTW +: DESTW]),
        .route(route[i]),
        .miss (miss[i])
      );
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
      always_comb begin
        for (int i = 0; i < N_IN; i++) want[o][i] = s_valid[i] && route[i][o];
      end

      xbar_arb #(
        .N_IN(N_IN), .USE_RR(USE_RR), .REL_LAST(REL_LAST),
        .MAX_XFER(MAX_XFER), .IDLE_TO(IDLE_TO)
      ) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (want[o]),
        .last_in  (s_last),
        .out_ready(m_ready[o]),
        .act      (m_valid[o]),
        .sel      (sel[o])
      );

      assign m_data[o*DW +: DW]       = s_data[sel[o]*DW +: DW];
      assign m_dest[o*DESTW +: DESTW] = s_dest[sel[o]*DESTW +: DESTW];
      assign m_last[o]                = s_last[sel[o]];

      // R9: stalled output is frozen
      p_stall_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid[o] && !m_ready[o] |=> m_valid[o] && $stable(m_data[o*DW +: DW])
                                       && $stable(m_dest[o*DESTW +: DESTW]));
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < N_IN; i++) begin
      s_ready[i] = miss[i];
      for (int o = 0; o < N_OUT; o++) begin
        gmat[i][o] = m_valid[o] && sel[o] == IW'(i);
        if (gmat[i][o] && m_ready[o]) s_ready[i] = 1'b1;
      end
    end
  end

  assign dec_err = miss;

  generate
    for (genvar i = 0; i < N_IN; i++) begin : g_chk
      // R1: an input is served by at most one output
      p_single_path_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gmat[i]));
      // R2: unroutable beats are swallowed, never forwarded
      p_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err[i] |-> s_ready[i] && gmat[i] == '0);
    end
  endgenerate
endmodule

// File: tb/sim_strm_xbar.sv
module sim_strm_xbar;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  s_valid, s_ready, s_last, dec_err;
  logic [47:0] s_data;
  logic [11:0] s_dest;
  logic [1:0]  m_valid, m_ready, m_last;
  logic [31:0] m_data;
  logic [7:0]  m_dest;

  logic [2:0]  f_valid, f_ready, f_last, f_err;
  logic [47:0] f_data;
  logic [11:0] f_dest;
  logic [1:0]  f_mvalid, f_mlast;
  logic [31:0] f_mdata;
  logic [7:0]  f_mdest;

  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  strm_xbar #(.N_IN(3), .N_OUT(2), .DW(16), .DESTW(4), .USE_RR(1), .REL_LAST(1),
    .MAX_XFER(4), .IDLE_TO(3), .LINK(6'b011111),
    .DEST_LO({4'd4, 4'd0}), .DEST_HI({4'd9, 4'd5})) u0 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_last(s_last), .s_dest(s_dest), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .m_last(m_last), .m_dest(m_dest), .dec_err(dec_err));

  strm_xbar #(.N_IN(3), .N_OUT(2), .DW(16), .DESTW(4), .USE_RR(0), .REL_LAST(1),
    .MAX_XFER(4), .IDLE_TO(3), .LINK(6'b011111),
    .DEST_LO({4'd4, 4'd0}), .DEST_HI({4'd9, 4'd5})) u1 (
    .clk(clk), .rst_n(rst_n), .s_valid(f_valid), .s_ready(f_ready), .s_data(f_data),
    .s_last(f_last), .s_dest(f_dest), .m_valid(f_mvalid), .m_ready(2'b11),
    .m_data(f_mdata), .m_last(f_mlast), .m_dest(f_mdest), .dec_err(f_err));

  // bench routing model: 0/1 = output, 2 = dropped
  function automatic int route(int i, int d);
    if (d <= 5) return 0;
    if (d >= 4 && d <= 9 && i != 2) return 1;
    return 2;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic put(int i, logic v, int d, logic l, logic [15:0] dat);
    s_valid[i]        = v;
    s_dest[i*4 +: 4]  = 4'(d);
    s_last[i]         = l;
    s_data[i*16 +: 16] = dat;
  endtask

  task automatic fput(int i, logic v, logic [15:0] dat);
    f_valid[i]         = v;
    f_dest[i*4 +: 4]   = 4'd0;
    f_last[i]          = 1'b1;
    f_data[i*16 +: 16] = dat;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [2:0] fired;
    int seq [3];
    int prev, src, r;
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    s_valid = '0; s_last = '0; s_data = '0; s_dest = '0; m_ready = 2'b11;
    f_valid = '0; f_last = '0; f_data = '0; f_dest = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #3;
    chk("reset m_valid", 32'(m_valid), 0);
    chk("reset s_ready", 32'(s_ready), 0);
    chk("reset dec_err", 32'(dec_err), 0);

    // R1 routing and overlap
    @(negedge clk); put(0, 1, 7, 1, 16'hA107); #3;
    chk("R1 valid", 32'(m_valid), 32'b10);
    chk("R1 data", 32'(m_data[31:16]), 32'hA107);
    chk("R1 last", 32'(m_last[1]), 1);
    chk("R1 ready", 32'(s_ready[0]), 1);
    @(negedge clk); put(0, 1, 4, 1, 16'hA104); #3;
    chk("R1 overlap valid", 32'(m_valid), 32'b01);
    chk("R1 overlap data", 32'(m_data[15:0]), 32'hA104);
    chk("R1 dest", 32'(m_dest[3:0]), 4);
    @(negedge clk); put(0, 0, 0, 0, 0); put(1, 1, 12, 1, 16'h1234); #3;
    chk("R2 miss ready", 32'(s_ready[1]), 1);
    chk("R2 miss err", 32'(dec_err), 32'b010);
    chk("R2 miss no out", 32'(m_valid), 0);
    @(negedge clk); put(1, 0, 0, 0, 0); put(2, 1, 7, 1, 16'h2777); #3;
    chk("R2 masked err", 32'(dec_err), 32'b100);
    chk("R2 masked ready", 32'(s_ready[2]), 1);
    chk("R2 masked no out", 32'(m_valid), 0);

    // R3 hold and R4 last release
    @(negedge clk); put(2, 0, 0, 0, 0); put(0, 1, 1, 0, 16'h0B01); #3;
    chk("R3 first data", 32'(m_data[15:0]), 32'h0B01);
    @(negedge clk); put(0, 0, 0, 0, 0); put(1, 1, 2, 1, 16'h1C01); #3;
    chk("R3 owner idle blocks", 32'(m_valid[0]), 0);
    chk("R3 rival waits", 32'(s_ready[1]), 0);
    @(negedge clk); put(0, 1, 1, 1, 16'h0B02); #3;
    chk("R3 owner resumes", 32'(m_data[15:0]), 32'h0B02);
    @(negedge clk); put(0, 0, 0, 0, 0); #3;
    chk("R4 rival after last", 32'(m_data[15:0]), 32'h1C01);
    chk("R4 rival ready", 32'(s_ready[1]), 1);

    // R5 transfer-count release
    @(negedge clk); put(1, 0, 0, 0, 0); put(0, 1, 0, 0, 16'h0D00); #3;
    chk("R5 beat0", 32'(m_data[15:0]), 32'h0D00);
    for (int k = 1; k < 4; k++) begin
      @(negedge clk); put(0, 1, 0, 0, 16'(16'h0D00 + k)); put(1, 1, 0, 1, 16'h1E00); #3;
      chk("R5 owner beat", 32'(m_data[15:0]), 32'(16'h0D00 + k));
    end
    @(negedge clk); put(0, 1, 0, 0, 16'h0D04); #3;
    chk("R5 released after limit", 32'(m_data[15:0]), 32'h1E00);
    @(negedge clk); put(1, 0, 0, 0, 0); put(0, 1, 0, 1, 16'h0D04); #3;
    chk("R5 owner back", 32'(m_data[15:0]), 32'h0D04);

    // R6 idle timeout
    @(negedge clk); put(0, 1, 0, 0, 16'h0F00); #3;
    chk("R6 grant", 32'(m_data[15:0]), 32'h0F00);
    @(negedge clk); put(0, 0, 0, 0, 0); put(1, 1, 0, 1, 16'h1E10); #3;
    chk("R6 idle1", 32'(m_valid[0]), 0);
    @(negedge clk); #3;
    chk("R6 idle2", 32'(m_valid[0]), 0);
    @(negedge clk); #3;
    chk("R6 idle3", 32'(m_valid[0]), 0);
    @(negedge clk); #3;
    chk("R6 rival served", 32'(m_valid[0]), 1);
    chk("R6 rival data", 32'(m_data[15:0]), 32'h1E10);

    // R9 back-pressure
    @(negedge clk); put(1, 0, 0, 0, 0); put(0, 1, 8, 1, 16'h0900); m_ready = 2'b01; #3;
    chk("R9 valid under stall", 32'(m_valid[1]), 1);
    chk("R9 no accept", 32'(s_ready[0]), 0);
    @(negedge clk); #3;
    chk("R9 data held", 32'(m_data[31:16]), 32'h0900);
    chk("R9 still blocked", 32'(s_ready[0]), 0);
    @(negedge clk); m_ready = 2'b11; #3;
    chk("R9 accept", 32'(s_ready[0]), 1);

    // R7 rotation among three requesters
    @(negedge clk);
    put(0, 1, 0, 1, 16'h0000); put(1, 1, 0, 1, 16'h1000); put(2, 1, 0, 1, 16'h2000);
    prev = 1;
    for (int k = 0; k < 6; k++) begin
      if (k > 0) @(negedge clk);
      #3;
      src = int'(m_data[15:12]);
      chk("R7 rotation", 32'(src), 32'((prev + 1) % 3));
      prev = src;
    end
    @(negedge clk); s_valid = '0;

    // R8 fixed priority on u1
    fput(0, 1, 16'h0000); fput(1, 1, 16'h1000); fput(2, 1, 16'h2000);
    for (int k = 0; k < 3; k++) begin
      if (k > 0) @(negedge clk);
      #3;
      chk("R8 lowest wins", 32'(f_mdata[15:12]), 0);
      chk("R8 others wait", 32'(f_ready), 32'b001);
    end
    @(negedge clk); fput(0, 0, 0); #3;
    chk("R8 next lowest", 32'(f_mdata[15:12]), 1);
    @(negedge clk); fput(1, 0, 0); #3;
    chk("R8 last one", 32'(f_mdata[15:12]), 2);
    @(negedge clk); f_valid = '0;

    // random traffic against routing model
    fired = '0;
    for (int i = 0; i < 3; i++) seq[i] = 0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      m_ready = 2'($urandom);
      for (int i = 0; i < 3; i++) begin
        if (!s_valid[i] || fired[i]) begin
          if ($urandom % 4 != 0) begin
            put(i, 1, int'($urandom % 16), ($urandom % 3 == 0), {4'(i), 12'(seq[i])});
            seq[i]++;
          end else begin
            put(i, 0, 0, 0, 0);
          end
        end
      end
      #3;
      fired = s_valid & s_ready;
      for (int i = 0; i < 3; i++) begin
        if (fired[i]) begin
          r = route(i, int'(s_dest[i*4 +: 4]));
          if (r == 2) chk("R2 random drop", 32'(dec_err[i]), 1);
          else chk("R1 random path", 32'(m_valid[r] && m_ready[r] &&
                   m_data[r*16 +: 16] == s_data[i*16 +: 16] && m_last[r] == s_last[i] &&
                   m_dest[r*4 +: 4] == s_dest[i*4 +: 4]), 1);
        end
      end
      for (int o = 0; o < 2; o++) begin
        if (m_valid[o] && m_ready[o]) begin
          src = int'(m_data[o*16 + 12 +: 4]);
          if (src < 3) chk("R9 random handshake", 32'(s_valid[src] && s_ready[src] &&
                           route(src, int'(s_dest[src*4 +: 4])) == o), 1);
          else chk("R1 random source", 32'(src), 0);
        end
      end
    end
    @(negedge clk); s_valid = '0;

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule